// File: doc/BRIEF.md
# Circular Buffer Pointer Tracker

This block keeps the bookkeeping for one circular buffer in memory. Software programs a first and a last byte address, a read pointer, a write pointer and a threshold. The block then derives the fill level, empty and full flags, and the offset of the active pointer from the first address. Each pointer carries a wrap-parity bit in its top bit, so a buffer holding zero bytes and one holding every byte look different without any counter. A hardware engine moves one pointer forward through an advance strobe. Software moves the other pointer by writing it.

In playback mode the hardware consumer moves the read pointer and software refills by rewriting the write pointer. The threshold compares against free space. In capture mode the hardware producer moves the write pointer and software drains by rewriting the read pointer. The threshold compares against filled space. A strobe that would read from an empty buffer or write into a full one is refused and reported. The threshold event is a single pulse. It stays quiet until software re-arms it.

Top module: `rbuf_track`

## Requirements
- R1: After reset both pointers are 0, empty is 1, full is 0, mark_evt and xrun_evt are 0, and the threshold event is disarmed.
- R2: empty is 1 exactly when rd_ptr equals wr_ptr in all 32 bits. full is 1 exactly when bits 30:0 of the two pointers are equal and bit 31 differs.
- R3: level equals (write address minus read address) modulo the buffer size, where size is last minus first plus one. When full, level equals the size.
- R4: Each accepted advance strobe moves the active pointer address up by 4 bytes. When the result would pass the last address, the address becomes the first address and bit 31 inverts.
- R5: With capture_mode=0 the strobe moves rd_ptr. A strobe while empty leaves rd_ptr unchanged and makes xrun_evt 1 for the following cycle.
- R6: With capture_mode=1 the strobe moves wr_ptr. A strobe while full leaves wr_ptr unchanged and makes xrun_evt 1 for the following cycle.
- R7: A write with cfg_we=1 takes effect from the next cycle, according to cfg_sel: 0 first address (bits 30:0), 1 last address (bits 30:0), 2 read pointer (all 32 bits), 3 write pointer (all 32 bits), 4 threshold. A software pointer write wins over a strobe to the same pointer.
- R8: Threshold bits 7:0 are ignored and treated as zero, so the threshold is always a multiple of 256 bytes.
- R9: While armed, the block checks whether the metric exceeds the threshold (strictly greater). The metric is free space (size minus level) in playback and level in capture. When the metric exceeds the threshold, mark_evt is 1 for exactly the next cycle.
- R10: Firing disarms the event. It stays disarmed until rearm is 1 for a cycle, and re-arming takes precedence over disarming in the same cycle.
- R11: position equals bits 30:0 of the active pointer (read in playback, write in capture) minus bits 30:0 of the first address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_mode | input | 1 | 0 playback, 1 capture |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| rearm | input | 1 | Re-arm the threshold event |
| hw_adv | input | 1 | Hardware advance strobe, 4 bytes per cycle |
| rd_ptr | output | 32 | Read pointer with wrap bit |
| wr_ptr | output | 32 | Write pointer with wrap bit |
| level | output | 32 | Filled bytes |
| empty | output | 1 | Buffer empty |
| full | output | 1 | Buffer full |
| position | output | 32 | Active pointer offset from first address |
| mark_evt | output | 1 | One-cycle threshold event |
| xrun_evt | output | 1 | One-cycle underflow (playback) or overflow (capture) event |

## Verification
The assertions check the following on every cycle:
- empty and full are never both high.
- A refused strobe holds its pointer and raises xrun_evt.
- An accepted playback strobe either steps the read address by four or wraps it to the first address with the parity inverted.
- A threshold pulse is never followed directly by another unless a re-arm came in between.

Only the bench scenarios can show the arithmetic results: the level across a wrap, the position offset, the ignored low threshold bits, and the exact cycle and count of threshold events in both modes.

// File: rtl/rbuf_pkg.sv
// Package: shared register select codes and default geometry for the
// circular buffer tracker. Assumes 32-bit pointers with a wrap bit on top.
package rbuf_pkg;
    localparam int RB_PTR_W    = 32;
    localparam int RB_STEP     = 4;
    localparam int RB_MARK_LSB = 8;

    typedef enum logic [2:0] {
        SEL_BASE = 3'd0,
        SEL_END  = 3'd1,
        SEL_RD   = 3'd2,
        SEL_WR   = 3'd3,
        SEL_MARK = 3'd4
    } rb_sel_e;
endpackage

// File: rtl/rbuf_regs.sv
// Module: rbuf_regs
// Holds first/last addresses, threshold and both pointers. Applies software
// writes and hardware advances, and flags refused advances.
// Assumes: last address >= first address, and the span is a multiple of STEP.
module rbuf_regs
    import rbuf_pkg::*;
#(
    parameter int PTR_W    = RB_PTR_W,
    parameter int STEP     = RB_STEP,
    parameter int MARK_LSB = RB_MARK_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_mode,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [PTR_W-1:0] cfg_wdata,
    input  logic             hw_adv,
    input  logic             empty,
    input  logic             full,
    output logic [PTR_W-2:0] base_q,
    output logic [PTR_W-2:0] end_q,
    output logic [PTR_W-1:0] mark_q,
    output logic [PTR_W-1:0] rd_q,
    output logic [PTR_W-1:0] wr_q,
    output logic             xrun_q
);
    localparam int AW = PTR_W - 1;

    rb_sel_e          sel;
    logic             blocked;
    logic             adv_ok;
    logic [PTR_W-1:0] rd_step;
    logic [PTR_W-1:0] wr_step;

    // Next pointer after one step: wrap to first address and invert parity past the end.
    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                  input logic [AW-1:0] b,
                                                  input logic [AW-1:0] e);
        logic [PTR_W-1:0] sum;
        sum = {1'b0, p[AW-1:0]} + PTR_W'(STEP);
        if (sum > {1'b0, e})
            return {~p[PTR_W-1], b};
        else
            return {p[PTR_W-1], sum[AW-1:0]};
    endfunction

    // Decode the select and decide whether a strobe may proceed.
    always_comb begin
        sel     = rb_sel_e'(cfg_sel);
        blocked = capture_mode ? full : empty;
        adv_ok  = hw_adv && !blocked;
        rd_step = step_ptr(rd_q, base_q, end_q);
        wr_step = step_ptr(wr_q, base_q, end_q);
    end

    // Register file update; a software pointer write beats a hardware step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            end_q  <= '0;
            mark_q <= '0;
            rd_q   <= '0;
            wr_q   <= '0;
            xrun_q <= 1'b0;
        end else begin
            xrun_q <= hw_adv && blocked;
            if (cfg_we && sel == SEL_BASE) base_q <= cfg_wdata[AW-1:0];
            if (cfg_we && sel == SEL_END)  end_q  <= cfg_wdata[AW-1:0];
            if (cfg_we && sel == SEL_MARK)
                mark_q <= {cfg_wdata[PTR_W-1:MARK_LSB], {MARK_LSB{1'b0}}};
            if (cfg_we && sel == SEL_RD)
                rd_q <= cfg_wdata;
            else if (adv_ok && !capture_mode)
                rd_q <= rd_step;
            if (cfg_we && sel == SEL_WR)
                wr_q <= cfg_wdata;
            else if (adv_ok && capture_mode)
                wr_q <= wr_step;
        end
    end
endmodule

// File: rtl/rbuf_level.sv
// Module: rbuf_level
// Pure combinational arithmetic: empty/full from the wrap bits, fill level
// modulo the span, free space and active pointer offset.
// Assumes: both pointer addresses lie within [first, last].
module rbuf_level
    import rbuf_pkg::*;
#(
    parameter int PTR_W = RB_PTR_W
) (
    input  logic             capture_mode,
    input  logic [PTR_W-1:0] rd_q,
    input  logic [PTR_W-1:0] wr_q,
    input  logic [PTR_W-2:0] base_q,
    input  logic [PTR_W-2:0] end_q,
    output logic [PTR_W-1:0] level,
    output logic [PTR_W-1:0] free_sp,
    output logic [PTR_W-1:0] position,
    output logic             empty,
    output logic             full
);
    localparam int AW = PTR_W - 1;

    logic [PTR_W-1:0] size;
    logic [AW-1:0]    ra;
    logic [AW-1:0]    wa;
    logic [AW-1:0]    act;

    // Level, flags and offset from the current register values.
    always_comb begin
        ra    = rd_q[AW-1:0];
        wa    = wr_q[AW-1:0];
        size  = {1'b0, end_q} - {1'b0, base_q} + PTR_W'(1);
        empty = (rd_q == wr_q);
        full  = (ra == wa) && (rd_q[PTR_W-1] != wr_q[PTR_W-1]);
        if (full)
            level = size;
        else if (wa >= ra)
            level = {1'b0, wa - ra};
        else
            level = {1'b0, wa} - {1'b0, ra} + size;
        free_sp  = size - level;
        act      = capture_mode ? wa : ra;
        position = {1'b0, act - base_q};
    end
endmodule

// File: rtl/rbuf_mark.sv
// Module: rbuf_mark
// One-shot threshold event. The metric is free space in playback and level
// in capture. Fires when the metric exceeds the threshold while armed, then disarms.
// Assumes: re-arm wins over a same-cycle disarm; disarmed after reset.
module rbuf_mark
    import rbuf_pkg::*;
#(
    parameter int PTR_W = RB_PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_mode,
    input  logic             rearm,
    input  logic [PTR_W-1:0] level,
    input  logic [PTR_W-1:0] free_sp,
    input  logic [PTR_W-1:0] mark_q,
    output logic             mark_evt
);
    logic armed;
    logic exceed;

    // Compare the mode's metric against the threshold.
    always_comb exceed = capture_mode ? (level > mark_q) : (free_sp > mark_q);

    // Arm state and registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            mark_evt <= 1'b0;
        end else begin
            mark_evt <= armed && exceed;
            if (rearm)
                armed <= 1'b1;
            else if (armed && exceed)
                armed <= 1'b0;
        end
    end
endmodule

// File: rtl/rbuf_track.sv
// Module: rbuf_track (top)
// Tracks one circular buffer: registers, pointer motion, level arithmetic
// and events. Assumes a single clock and a synchronous active-low reset.
module rbuf_track
    import rbuf_pkg::*;
#(
    parameter int PTR_W    = RB_PTR_W,
    parameter int STEP     = RB_STEP,
    parameter int MARK_LSB = RB_MARK_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_mode,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [PTR_W-1:0] cfg_wdata,
    input  logic             rearm,
    input  logic             hw_adv,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] level,
    output logic             empty,
    output logic             full,
    output logic [PTR_W-1:0] position,
    output logic             mark_evt,
    output logic             xrun_evt
);
    logic [PTR_W-2:0] base_q;
    logic [PTR_W-2:0] end_q;
    logic [PTR_W-1:0] mark_q;
    logic [PTR_W-1:0] free_sp;

    rbuf_regs #(.PTR_W(PTR_W), .STEP(STEP), .MARK_LSB(MARK_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .capture_mode(capture_mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .hw_adv(hw_adv), .empty(empty), .full(full),
        .base_q(base_q), .end_q(end_q), .mark_q(mark_q),
        .rd_q(rd_ptr), .wr_q(wr_ptr), .xrun_q(xrun_evt)
    );

    rbuf_level #(.PTR_W(PTR_W)) u_level (
        .capture_mode(capture_mode), .rd_q(rd_ptr), .wr_q(wr_ptr),
        .base_q(base_q), .end_q(end_q), .level(level), .free_sp(free_sp),
        .position(position), .empty(empty), .full(full)
    );

    rbuf_mark #(.PTR_W(PTR_W)) u_mark (
        .clk(clk), .rst_n(rst_n), .capture_mode(capture_mode), .rearm(rearm),
        .level(level), .free_sp(free_sp), .mark_q(mark_q), .mark_evt(mark_evt)
    );
endmodule

// File: rtl/rbuf_track_chk.sv
// Module: rbuf_track_chk
// Concurrent checks on the tracker, bound into every rbuf_track instance.
module rbuf_track_chk #(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             capture_mode,
    input logic             cfg_we,
    input logic             rearm,
    input logic             hw_adv,
    input logic             empty,
    input logic             full,
    input logic             mark_evt,
    input logic             xrun_evt,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-2:0] base_addr
);
    // R2: the two flags exclude each other
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R4: an accepted playback step either adds four or wraps with parity inverted
    a_r4_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_mode && hw_adv && !empty && !cfg_we) |=>
        ((rd_ptr[PTR_W-2:0] == $past(rd_ptr[PTR_W-2:0]) + (PTR_W-1)'(4)) &&
         (rd_ptr[PTR_W-1] == $past(rd_ptr[PTR_W-1]))) ||
        ((rd_ptr[PTR_W-2:0] == base_addr) && (rd_ptr[PTR_W-1] != $past(rd_ptr[PTR_W-1]))));

    // R5: refused playback step holds the read pointer and reports
    a_r5_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_mode && hw_adv && empty && !cfg_we) |=>
        (xrun_evt && rd_ptr == $past(rd_ptr)));

    // R6: refused capture step holds the write pointer and reports
    a_r6_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_mode && hw_adv && full && !cfg_we) |=>
        (xrun_evt && wr_ptr == $past(wr_ptr)));

    // R10: no back-to-back pulse without a re-arm at the firing edge
    a_r10_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_evt && !$past(rearm)) |=> !mark_evt);
endmodule

bind rbuf_track rbuf_track_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .capture_mode(capture_mode), .cfg_we(cfg_we),
    .rearm(rearm), .hw_adv(hw_adv), .empty(empty), .full(full),
    .mark_evt(mark_evt), .xrun_evt(xrun_evt), .rd_ptr(rd_ptr),
    .wr_ptr(wr_ptr), .base_addr(base_q)
);

// File: tb/sim_rbuf_track.sv
`timescale 1ns/1ps
module sim_rbuf_track;
    import rbuf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        rearm = 1'b0;
    logic        hw_adv = 1'b0;
    logic [31:0] rd_ptr, wr_ptr, level, position;
    logic        empty, full, mark_evt, xrun_evt;

    int errors = 0;
    int checks = 0;
    int mark_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rbuf_track u0 (
        .clk(clk), .rst_n(rst_n), .capture_mode(capture_mode), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rearm(rearm), .hw_adv(hw_adv),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .level(level), .empty(empty),
        .full(full), .position(position), .mark_evt(mark_evt), .xrun_evt(xrun_evt)
    );

    // count threshold pulses, sampled away from the active edge
    always @(negedge clk) if (rst_n && mark_evt) mark_cnt++;

    typedef struct packed {
        logic        is_adv;
        logic [2:0]  sel;
        logic [31:0] arg;
        logic        chk;
        logic [31:0] lvl;
        logic        emp;
        logic        ful;
        logic [31:0] wp;
    } vec_t;

    // capture mode: first 0x1000, last 0x10FF (256 bytes)
    localparam vec_t VEC [10] = '{
        '{1'b0, 3'd0, 32'h0000_1000, 1'b0, 32'd0,   1'b0, 1'b0, 32'h0},
        '{1'b0, 3'd1, 32'h0000_10FF, 1'b0, 32'd0,   1'b0, 1'b0, 32'h0},
        '{1'b0, 3'd2, 32'h0000_1000, 1'b0, 32'd0,   1'b0, 1'b0, 32'h0},
        '{1'b0, 3'd3, 32'h0000_1000, 1'b1, 32'd0,   1'b1, 1'b0, 32'h0000_1000},
        '{1'b1, 3'd0, 32'd16,        1'b1, 32'd64,  1'b0, 1'b0, 32'h0000_1040},
        '{1'b1, 3'd0, 32'd48,        1'b1, 32'd256, 1'b0, 1'b1, 32'h8000_1000},
        '{1'b1, 3'd0, 32'd1,         1'b1, 32'd256, 1'b0, 1'b1, 32'h8000_1000},
        '{1'b0, 3'd2, 32'h0000_1080, 1'b1, 32'd128, 1'b0, 1'b0, 32'h8000_1000},
        '{1'b1, 3'd0, 32'd8,         1'b1, 32'd160, 1'b0, 1'b0, 32'h8000_1020},
        '{1'b0, 3'd2, 32'h8000_1020, 1'b1, 32'd0,   1'b1, 1'b0, 32'h8000_1020}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            hw_adv = 1'b1;
            @(negedge clk);
        end
        hw_adv = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 rd_ptr", rd_ptr, 32'h0);
        chk("R1 wr_ptr", wr_ptr, 32'h0);
        chk("R1 empty", {31'd0, empty}, 32'd1);
        chk("R1 full", {31'd0, full}, 32'd0);
        chk("R1 mark_evt", {31'd0, mark_evt}, 32'd0);
        chk("R1 xrun_evt", {31'd0, xrun_evt}, 32'd0);

        // table walk: R2 R3 R4 R6 R7
        capture_mode = 1'b1;
        for (int k = 0; k < 10; k++) begin
            if (VEC[k].is_adv) adv(int'(VEC[k].arg));
            else wr_reg(VEC[k].sel, VEC[k].arg);
            if (VEC[k].chk) begin
                chk("R3 level", level, VEC[k].lvl);
                chk("R2 empty", {31'd0, empty}, {31'd0, VEC[k].emp});
                chk("R2 full", {31'd0, full}, {31'd0, VEC[k].ful});
                chk("R4 wr_ptr", wr_ptr, VEC[k].wp);
            end
        end
        chk("R7 rd_ptr write", rd_ptr, 32'h8000_1020);
        chk("R11 capture position", position, 32'h20);

        // R6 overflow refused
        wr_reg(SEL_BASE, 32'h0);
        wr_reg(SEL_END, 32'hFF);
        wr_reg(SEL_RD, 32'h0);
        wr_reg(SEL_WR, 32'h8000_0000);
        chk("R2 full set", {31'd0, full}, 32'd1);
        adv(1);
        chk("R6 xrun_evt", {31'd0, xrun_evt}, 32'd1);
        chk("R6 wr_ptr held", wr_ptr, 32'h8000_0000);
        idle(1);
        chk("R6 xrun one cycle", {31'd0, xrun_evt}, 32'd0);

        // R8 R9 capture threshold, low bits ignored
        wr_reg(SEL_END, 32'h3FF);
        wr_reg(SEL_WR, 32'h0);
        wr_reg(SEL_MARK, 32'h1FF);
        mark_cnt = 0;
        rearm = 1'b1; @(negedge clk); rearm = 1'b0;
        idle(2);
        chk("R9 capture level 0 silent", mark_cnt, 0);
        adv(64);
        idle(2);
        chk("R8 level 256 not above 256", mark_cnt, 0);
        adv(1);
        idle(2);
        chk("R8 level 260 fires", mark_cnt, 1);

        // playback: R5 R4 R11 R9 R10
        capture_mode = 1'b0;
        wr_reg(SEL_MARK, 32'h0);
        wr_reg(SEL_BASE, 32'h2000);
        wr_reg(SEL_END, 32'h20FF);
        wr_reg(SEL_RD, 32'h2000);
        wr_reg(SEL_WR, 32'h8000_2000);
        chk("R3 playback full level", level, 32'd256);
        adv(10);
        chk("R4 rd_ptr step", rd_ptr, 32'h2028);
        chk("R3 level 216", level, 32'd216);
        chk("R11 playback position", position, 32'h28);
        mark_cnt = 0;
        idle(3);
        chk("R10 disarmed stays silent", mark_cnt, 0);
        rearm = 1'b1; @(negedge clk); rearm = 1'b0;
        chk("R9 no pulse at arm edge", {31'd0, mark_evt}, 32'd0);
        @(negedge clk);
        chk("R9 pulse next cycle", {31'd0, mark_evt}, 32'd1);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'd0, mark_evt}, 32'd0);
        idle(5);
        chk("R10 one shot", mark_cnt, 1);
        adv(54);
        chk("R4 wrap parity", rd_ptr, 32'h8000_2000);
        chk("R2 empty after wrap", {31'd0, empty}, 32'd1);
        adv(1);
        chk("R5 xrun_evt", {31'd0, xrun_evt}, 32'd1);
        chk("R5 rd_ptr held", rd_ptr, 32'h8000_2000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule